// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker turns a 32-bit effective address into a physical address by searching an in-memory hashed page table. On an accepted start it selects one of sixteen segment words with the top four address bits, forms a 24-bit virtual segment identifier and builds a 32-bit compare word. From that identifier and the page index it derives a primary hash and its 19-bit complement. Each hash, combined with a table register, gives the address of a 64-byte page-table group. Both group addresses and the compare word are exported as soon as the walk begins.

The block then streams the primary group through a single synchronous 32-bit read port, one word per cycle, upper word before lower word. An entry hits only when its upper word equals the compare word exactly. If no primary entry hits, the same scan runs over the secondary group with the hash-select bit set in the compare word. A done pulse reports the outcome together with the lower word of the hit entry and the physical address it yields.

Top module: `hpt_walker`

## Requirements
- R1: While reset is high and on the cycle after it, busy, done and mem_req are low; match, pte_lo and pa read zero.
- R2: The compare word is bit 31 = 1, bits [30:7] = the low 24 bits of segment word ea[31:28], bit 6 = 0, bits [5:0] = ea[27:22]; it appears on cmp_word the cycle after an accepted start.
- R3: With h = vsid[18:0] XOR ea[27:12], grp_pri = {tbl[31:25], tbl[24:16] OR (h[18:10] AND tbl[8:0]), h[9:0], 6'b0}; grp_sec uses h XOR 0x7FFFF in the same formula; both appear the cycle after an accepted start, whatever the search finds.
- R4: Reads go out one per cycle, consecutive within a group: entry i's upper word at base+8i, its lower word at base+8i+4; the data for a read is taken from mem_rdata in the following cycle. The first read is issued the cycle after the start is accepted.
- R5: A primary hit at entry k stops the scan after its lower word is read; done is high 2k+3 cycles after the start edge with match = 1.
- R6: An entry hits only when its upper word equals the active compare word in all 32 bits; a word differing only in the valid bit or the hash-select bit is skipped.
- R7: Only after all eight primary entries miss, the secondary group is scanned from grp_sec with bit 6 of the compare word set; its first read comes 17 cycles after the start edge, and a hit at entry k gives done at 20+2k cycles.
- R8: When both groups miss, done is high 34 cycles after the start edge with match = 0, pte_lo = 0 and pa = 0.
- R9: On a hit, pte_lo holds the entry's lower word and pa = {pte_lo[31:12], ea[11:0]}.
- R10: A start pulse while busy is ignored: the running walk, its reads and its exported values are unchanged.
- R11: done is a one-cycle pulse; busy is high from the cycle after the start edge until the cycle done rises, and low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk; accepted only when not busy |
| ea | input | 32 | Effective address to translate |
| seg_flat | input | 512 | Sixteen 32-bit segment words, word i at bits [32i+31:32i] |
| tbl_reg | input | 32 | Table register: origin in [31:16], mask in [8:0] |
| mem_req | output | 1 | Read request this cycle |
| mem_addr | output | 32 | Byte address of the 32-bit word to read |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| match | output | 1 | Last walk found an entry |
| pte_lo | output | 32 | Lower word of the hit entry, zero on a miss |
| pa | output | 32 | Physical address, zero on a miss |
| grp_pri | output | 32 | Primary group address |
| grp_sec | output | 32 | Secondary group address |
| cmp_word | output | 32 | Primary compare word |

## Verification
The assertions take for granted a memory that answers every request with exactly one cycle of latency and never stalls, since the block has no wait input; the bench memory is a sparse array read on every requested edge, with unwritten words reading zero so they can never carry the valid bit. Segment and table inputs only matter at the accepted start, so the bench changes them only between walks, except for the deliberate busy-time start pulse that must be ignored. Each group is filled with decoys that differ from the compare word only in the valid bit or the hash-select bit, so a hit is taken solely from the entry placed on purpose.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SEG_CNT  = 16;
  localparam int unsigned VSID_W   = 24;
  localparam int unsigned HASH_W   = 19;
  localparam int unsigned API_W    = 6;
  localparam int unsigned MASK_W   = 9;
  localparam int unsigned PAGE_LSB = 12;

  localparam logic [WORD_W-1:0] HSEL_BIT = 32'h0000_0040;
  localparam logic [HASH_W-1:0] HASH_FLIP = '1;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_PRI  = 2'd1,
    SC_SEC  = 2'd2
  } scan_state_t;

  // Group base: origin high bits, origin mid bits widened by masked hash,
  // low hash bits select the 64-byte group.
  function automatic logic [WORD_W-1:0] group_base(input logic [HASH_W-1:0] h,
                                                   input logic [WORD_W-1:0] tbl);
    logic [MASK_W-1:0] mid;
    mid = tbl[24:16] | (h[18:10] & tbl[MASK_W-1:0]);
    return {tbl[31:25], mid, h[9:0], 6'b00_0000};
  endfunction

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0]         ea,
  input  logic [SEG_CNT*WORD_W-1:0] seg_flat,
  input  logic [WORD_W-1:0]         tbl,
  output logic [2*WORD_W-1:0]       grp_flat,
  output logic [WORD_W-1:0]         cmp
);

  logic [3:0]        seg_idx;
  logic [WORD_W-1:0] seg_word;
  logic [VSID_W-1:0] vsid;
  logic [HASH_W-1:0] h_pri;
  logic [7:0]        unused_seg_hi;

  assign seg_idx  = ea[31:28];
  assign seg_word = seg_flat[{seg_idx, 5'd0} +: WORD_W];
  assign vsid     = seg_word[VSID_W-1:0];
  assign unused_seg_hi = seg_word[WORD_W-1:VSID_W];

  assign h_pri = vsid[HASH_W-1:0] ^ {3'b000, ea[27:12]};

  // R2: valid, vsid, hash-select (clear), abbreviated page index
  assign cmp = {1'b1, vsid, 1'b0, ea[27:22]};

  // Index 0 is the primary group, index 1 the secondary (complemented hash).
  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam logic [HASH_W-1:0] FLIP = (g == 0) ? '0 : HASH_FLIP;
    assign grp_flat[g*WORD_W +: WORD_W] = group_base(h_pri ^ FLIP, tbl);
  end

endmodule

// File: rtl/hpt_scan.sv
module hpt_scan
  import hpt_pkg::*;
#(
  parameter int unsigned N_ENT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [WORD_W-1:0] go_base,
  input  logic [WORD_W-1:0] go_cmp,
  input  logic [WORD_W-1:0] sec_base,
  input  logic [WORD_W-1:0] sec_cmp,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              fin,
  output logic              hit,
  output logic [WORD_W-1:0] lo_word
);

  localparam int unsigned N_WORD = 2 * N_ENT;
  localparam int unsigned WIDX_W = $clog2(N_WORD);
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(N_WORD - 1);

  scan_state_t       st_q;
  logic              req_q, rv_q, found_q, fin_q, hit_q;
  logic [WORD_W-1:0] addr_q, cmp_act_q, lo_q;
  logic [WIDX_W-1:0] widx_q, ridx_q;

  logic hit_now, last_issue, grab, pass_miss, keep_issuing;

  assign hit_now      = rv_q && !ridx_q[0] && !found_q && (mem_rdata == cmp_act_q);
  assign last_issue   = (widx_q == LAST_W);
  assign grab         = rv_q && ridx_q[0] && found_q;
  assign pass_miss    = rv_q && (ridx_q == LAST_W) && !found_q;
  assign keep_issuing = req_q && !last_issue && !hit_now && !found_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SC_IDLE;
      req_q     <= 1'b0;
      rv_q      <= 1'b0;
      found_q   <= 1'b0;
      fin_q     <= 1'b0;
      hit_q     <= 1'b0;
      addr_q    <= '0;
      cmp_act_q <= '0;
      lo_q      <= '0;
      widx_q    <= '0;
      ridx_q    <= '0;
    end else begin
      fin_q  <= 1'b0;
      rv_q   <= req_q;
      ridx_q <= widx_q;
      if (st_q == SC_IDLE) begin
        if (go) begin
          st_q      <= SC_PRI;
          req_q     <= 1'b1;
          addr_q    <= go_base;
          widx_q    <= '0;
          found_q   <= 1'b0;
          cmp_act_q <= go_cmp;
        end
      end else begin
        if (hit_now) found_q <= 1'b1;
        if (keep_issuing) begin
          widx_q <= widx_q + 1'b1;
          addr_q <= addr_q + 32'd4;
        end else begin
          req_q <= 1'b0;
        end
        if (grab) begin
          fin_q <= 1'b1;
          hit_q <= 1'b1;
          lo_q  <= mem_rdata;
          st_q  <= SC_IDLE;
        end else if (pass_miss) begin
          if (st_q == SC_PRI) begin
            st_q      <= SC_SEC;
            req_q     <= 1'b1;
            addr_q    <= sec_base;
            widx_q    <= '0;
            cmp_act_q <= sec_cmp | HSEL_BIT;
          end else begin
            fin_q <= 1'b1;
            hit_q <= 1'b0;
            lo_q  <= '0;
            st_q  <= SC_IDLE;
          end
        end
      end
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign busy     = (st_q != SC_IDLE);
  assign fin      = fin_q;
  assign hit      = hit_q;
  assign lo_word  = lo_q;

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int unsigned N_ENT = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [31:0]               ea,
  input  logic [SEG_CNT*32-1:0]     seg_flat,
  input  logic [31:0]               tbl_reg,
  output logic                      mem_req,
  output logic [31:0]               mem_addr,
  input  logic [31:0]               mem_rdata,
  output logic                      busy,
  output logic                      done,
  output logic                      match,
  output logic [31:0]               pte_lo,
  output logic [31:0]               pa,
  output logic [31:0]               grp_pri,
  output logic [31:0]               grp_sec,
  output logic [31:0]               cmp_word
);

  logic [2*WORD_W-1:0]   grp_flat;
  logic [WORD_W-1:0]     cmp_c;
  logic                  go;
  logic [PAGE_LSB-1:0]   off_q;
  logic [WORD_W-1:0]     grp_pri_q, grp_sec_q, cmp_q;
  logic [WORD_W-1:0]     lo_w;
  logic                  hit_w;

  hpt_hash u_hash (
    .ea       (ea),
    .seg_flat (seg_flat),
    .tbl      (tbl_reg),
    .grp_flat (grp_flat),
    .cmp      (cmp_c)
  );

  assign go = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q     <= '0;
      grp_pri_q <= '0;
      grp_sec_q <= '0;
      cmp_q     <= '0;
    end else if (go) begin
      off_q     <= ea[PAGE_LSB-1:0];
      grp_pri_q <= grp_flat[0 +: WORD_W];
      grp_sec_q <= grp_flat[WORD_W +: WORD_W];
      cmp_q     <= cmp_c;
    end
  end

  hpt_scan #(.N_ENT(N_ENT)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_base   (grp_flat[0 +: WORD_W]),
    .go_cmp    (cmp_c),
    .sec_base  (grp_sec_q),
    .sec_cmp   (cmp_q),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .fin       (done),
    .hit       (hit_w),
    .lo_word   (lo_w)
  );

  assign match    = hit_w;
  assign pte_lo   = lo_w;
  assign pa       = hit_w ? {lo_w[WORD_W-1:PAGE_LSB], off_q} : '0;
  assign grp_pri  = grp_pri_q;
  assign grp_sec  = grp_sec_q;
  assign cmp_word = cmp_q;

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        match,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic [31:0] pte_lo,
  input logic [31:0] pa,
  input logic [31:0] grp_pri,
  input logic [31:0] grp_sec,
  input logic [31:0] cmp_word
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_req));

  assert_groups_complement_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (((grp_pri ^ grp_sec) & 32'h0000_FFC0) == 32'h0000_FFC0));

  assert_first_read_at_base_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !$past(mem_req)) |-> ((mem_addr == grp_pri) || (mem_addr == grp_sec)));

  assert_reads_sequential_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + 32'd4));

  assert_read_only_when_busy_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !match) |-> (pte_lo == 32'h0 && pa == 32'h0));

  assert_pa_from_entry_R9: assert property (@(posedge clk) disable iff (rst)
    (done && match) |-> (pa[31:12] == pte_lo[31:12]));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(grp_pri) && $stable(grp_sec) && $stable(cmp_word)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_ends_with_done_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

bind hpt_walker hpt_walker_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .match    (match),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .pte_lo   (pte_lo),
  .pa       (pa),
  .grp_pri  (grp_pri),
  .grp_sec  (grp_sec),
  .cmp_word (cmp_word)
);

// File: tb/test_hpt_walker.sv
`timescale 1ns/1ps
module test_hpt_walker;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [31:0]  ea = '0;
  logic [511:0] seg_flat;
  logic [31:0]  tbl_reg = '0;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic [31:0]  mem_rdata = '0;
  logic         busy, done, match;
  logic [31:0]  pte_lo, pa, grp_pri, grp_sec, cmp_word;

  logic [31:0] seg [16];
  logic [31:0] mem [logic [31:0]];
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hpt_walker i_hpt_walker (
    .clk(clk), .rst(rst), .start(start), .ea(ea), .seg_flat(seg_flat),
    .tbl_reg(tbl_reg), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .match(match),
    .pte_lo(pte_lo), .pa(pa), .grp_pri(grp_pri), .grp_sec(grp_sec),
    .cmp_word(cmp_word)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // Synchronous read memory: data one cycle after the request (R4)
  always @(posedge clk) if (mem_req) mem_rdata <= rd(mem_addr);

  function automatic logic [31:0] grp_of(input logic [31:0] h, input logic [31:0] t);
    logic [31:0] mid;
    mid = ((t >> 16) & 32'h1FF) | ((h >> 10) & t & 32'h1FF);
    return (t & 32'hFE00_0000) | (mid << 16) | ((h & 32'h3FF) << 6);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // mode 0: primary hit at entry k; 1: secondary hit at entry k; 2: miss
  task automatic walk(input logic [31:0] a, input logic [31:0] t, input int mode,
                      input int k, input bit poke, input string lbl);
    logic [31:0] vsid, h1, h2, g1, g2, c1, c2, lo, exp_lo, exp_pa;
    int lat, np, ns;
    int q_cyc[$];
    logic [31:0] q_adr[$];
    string tag;
    vsid = seg[a[31:28]] & 32'h00FF_FFFF;
    h1 = (vsid & 32'h7FFFF) ^ ((a >> 12) & 32'hFFFF);
    h2 = h1 ^ 32'h7FFFF;
    g1 = grp_of(h1, t);
    g2 = grp_of(h2, t);
    c1 = 32'h8000_0000 | (vsid << 7) | ((a >> 22) & 32'h3F);
    c2 = c1 | 32'h40;
    lo = ((32'h13579 + k + mode * 32'h100) << 12) | 32'h3A5;
    mem.delete();
    // R6 decoys: differ only in hash-select or valid bit
    for (int i = 0; i < 8; i++) begin
      mem[g1 + 8*i]     = (i % 2 == 0) ? c2 : (c1 & 32'h7FFF_FFFF);
      mem[g1 + 8*i + 4] = 32'hDEAD_0000 + i;
      mem[g2 + 8*i]     = (i % 2 == 0) ? c1 : (c2 & 32'h7FFF_FFFF);
      mem[g2 + 8*i + 4] = 32'hBEEF_0000 + i;
    end
    if (mode == 0) begin
      mem[g1 + 8*k] = c1; mem[g1 + 8*k + 4] = lo;
      mem[g2] = c2;  // a real secondary entry that must not be reached
      np = 2*k + 2; ns = 0; lat = 2*k + 3; tag = "R5";
    end else if (mode == 1) begin
      mem[g2 + 8*k] = c2; mem[g2 + 8*k + 4] = lo;
      np = 16; ns = 2*k + 2; lat = 20 + 2*k; tag = "R7";
    end else begin
      np = 16; ns = 16; lat = 34; tag = "R8";
    end
    for (int w = 0; w < np; w++) begin q_cyc.push_back(w); q_adr.push_back(g1 + 4*w); end
    for (int w = 0; w < ns; w++) begin q_cyc.push_back(17 + w); q_adr.push_back(g2 + 4*w); end
    exp_lo = (mode == 2) ? 32'h0 : lo;
    exp_pa = (mode == 2) ? 32'h0 : {lo[31:12], a[11:0]};

    @(negedge clk);
    ea = a; tbl_reg = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= lat + 1; n++) begin
      if (q_cyc.size() > 0 && q_cyc[0] == n) begin
        chk(mem_req && mem_addr == q_adr[0], {lbl, " R4 read address"}, mem_addr, q_adr[0]);
        void'(q_cyc.pop_front()); void'(q_adr.pop_front());
      end else begin
        chk(!mem_req, {lbl, " R4 no read expected"}, {31'b0, mem_req}, 32'h0);
      end
      chk(done == (n == lat), {lbl, " ", tag, " done timing"}, {31'b0, done}, {31'b0, n == lat});
      chk(busy == (n < lat), {lbl, " R11 busy"}, {31'b0, busy}, {31'b0, n < lat});
      if (n == 0 || n == lat) begin
        chk(cmp_word == c1, {lbl, " R2 compare word"}, cmp_word, c1);
        chk(grp_pri == g1, {lbl, " R3 primary group"}, grp_pri, g1);
        chk(grp_sec == g2, {lbl, " R3 secondary group"}, grp_sec, g2);
      end
      if (n == lat) begin
        chk(match == (mode != 2), {lbl, " ", tag, " match"}, {31'b0, match}, {31'b0, mode != 2});
        chk(pte_lo == exp_lo, {lbl, " R6 entry lower word"}, pte_lo, exp_lo);
        chk(pa == exp_pa, {lbl, " R9 physical address"}, pa, exp_pa);
      end
      // R10: start pulse with a different address while busy
      if (poke && n == 4) begin start = 1'b1; ea = ~a; end
      if (poke && n == 5) begin start = 1'b0; ea = a; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      seg[i] = 32'hF100_0000 | ((i * 32'h0004_1A37 + 32'h0000_0321) & 32'h00FF_FFFF);
      seg_flat[i*32 +: 32] = seg[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req, "R1 idle flags", {29'b0, busy, done, mem_req}, 32'h0);
    chk(!match && pte_lo == 0 && pa == 0, "R1 result regs", pte_lo, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 after release", {30'b0, busy, mem_req}, 32'h0);

    walk(32'h3123_4ABC, 32'h0012_0000, 0, 0, 1'b0, "prim0");
    walk(32'hA7F0_1FFF, 32'h0E40_00FF, 0, 7, 1'b0, "prim7");
    walk(32'h5C0F_F123, 32'h0200_0003, 1, 3, 1'b0, "sec3");
    walk(32'h0000_0000, 32'h7F80_01FF, 1, 0, 1'b0, "sec0");
    walk(32'hE9AB_C777, 32'h1234_0155, 1, 7, 1'b0, "sec7");
    walk(32'hF000_0000, 32'h0001_0000, 2, 0, 1'b0, "miss");
    walk(32'h6FED_CBA9, 32'h4C00_0011, 0, 2, 1'b1, "R10 busy start");
    walk(32'h8765_4321, 32'h0300_0100, 2, 0, 1'b1, "R10 busy miss");

    summary();
    $finish;
  end

endmodule